// File: doc/BRIEF.md
# Locked Configuration Register Guard

This block holds the configuration of a watchdog: two 32-bit control words, a 16-bit warning timeout value, a 16-bit firing timeout value, and a protection word that holds a 16-bit update key and a 4-bit window exponent. Software reaches these through a plain write port made of a strobe, a 3-bit address and a 32-bit data word. Bit 0 of control word A is the lock. While the lock is clear, the guarded registers take writes freely. While the lock is set, a guarded write is accepted only after a correct key has been written to the key port. The accepted write must arrive before a window of 128·2^N clock cycles expires, and one successful unlock admits only one guarded write.

Every write to a control word must carry even parity over all 32 bits, whether or not the lock is set. A write with odd parity is thrown away. The block keeps three sticky event flags: parity error, lock violation and key failure. Software clears them by writing ones to the flag address. Control word B holds an interrupt-enable bit and a reset-enable bit for each flag. The interrupt request and the reset request are the OR of the flags masked by those enables. The counter these values configure lives outside this block.

Top module: `cfg_guard`

## Requirements
- R1: After reset, both control words, both timeout values and all three flags are zero, the unlock window is closed, and the interrupt and reset requests are low. The update key resets to 16'hC0DE and the window exponent resets to 0.
- R2: While the lock (control word A bit 0) is clear, a write to address 0 (control A), 1 (control B), 2 (warning value, data[15:0]) or 3 (firing value, data[15:0]) takes effect at the clock edge that samples it. Control words must still have even parity.
- R3: A write to address 0 or 1 whose 32 data bits XOR to one is discarded and sets flag bit 0 (parity error). Writes to addresses 2, 3 and 5 are not parity checked.
- R4: While the lock is set and no window is open, a write to address 0, 1, 2, 3 or 5 is discarded and sets flag bit 1 (violation).
- R5: A write to address 4 opens the unlock window when data[15:0] equals the stored key. Otherwise it sets flag bit 2 (key failure) and does not open the window.
- R6: An open window admits exactly one guarded write and closes at the edge of that write. A second guarded write is then a violation.
- R7: The window that opens at edge E0 admits a guarded write at edges E1 through E(128·2^N) and closes at edge E(128·2^N). N is data[19:16] and the key is data[15:0] of the protection word at address 5.
- R8: A write to address 6 clears each flag whose data bit (2:0) is one and leaves the others unchanged.
- R9: The interrupt request is the OR of flags AND control B bits 2:0. The reset request is the OR of flags AND control B bits 6:4. Both use the same flag bit order.
- R10: A guarded control write that both hits a closed lock and has odd parity sets both flag bits 0 and 1. An odd-parity write made through an open window is discarded, sets flag bit 0 and still uses up the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| ctl_a | output | 32 | Control word A (bit 0 is the lock) |
| ctl_b | output | 32 | Control word B (bits 2:0 interrupt enables, bits 6:4 reset enables) |
| warn_val | output | 16 | Warning timeout value |
| fire_val | output | 16 | Firing timeout value |
| flags | output | 3 | Sticky flags: bit 0 parity, bit 1 violation, bit 2 key failure |
| unlock_open | output | 1 | Unlock window is open |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | Reset request |

## Verification
Two pairs of functions can act in the same cycle. The first pair is the expiry of the window and a guarded write. The bench unlocks the block, idles for exactly 128·2^N − 1 cycles and then writes, so the write lands on the edge where the window closes. That write must be accepted. One cycle later, a write must be rejected as a violation. The bench runs this for N=0 and N=1. The second pair is the lock check and the parity check. Odd-parity control writes are made with the window closed, where both flags must rise, and with the window open, where only the parity flag rises and the window must still close.

// File: rtl/cfg_guard_pkg.sv
// Package: shared addresses, flag positions and field positions of the
// configuration guard. Assumes a 3-bit word address space.
package cfg_guard_pkg;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned NFLAG = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTL_A = 3'd0,
        A_CTL_B = 3'd1,
        A_WARN  = 3'd2,
        A_FIRE  = 3'd3,
        A_KEY   = 3'd4,
        A_PROT  = 3'd5,
        A_FLAGS = 3'd6
    } reg_addr_e;

    localparam int unsigned F_PAR  = 0;
    localparam int unsigned F_VIOL = 1;
    localparam int unsigned F_KEY  = 2;

    localparam int unsigned LOCK_BIT   = 0;
    localparam int unsigned IRQ_EN_LSB = 0;
    localparam int unsigned RST_EN_LSB = 4;
    localparam int unsigned EXP_LSB    = 16;
endpackage

// File: rtl/cfg_guard_decode.sv
// Module: cfg_guard_decode
// Classifies one bus write. It decides whether the write commits, whether it
// uses up the unlock window, and which events it raises.
// Assumes: one write per cycle; the lock and window state come from flops.
module cfg_guard_decode
    import cfg_guard_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lock,
    input  logic              win_open,
    output logic              commit,
    output logic              consume,
    output logic              key_try,
    output logic              par_evt,
    output logic              viol_evt,
    output logic [NFLAG-1:0]  clr_mask
);
    logic is_ctl;
    logic guarded;
    logic access;
    logic blocked;
    logic par_bad;

    // Address classes: control words and all lock-protected registers.
    always_comb begin
        is_ctl  = (wr_addr == A_CTL_A) || (wr_addr == A_CTL_B);
        guarded = is_ctl || (wr_addr == A_WARN) || (wr_addr == A_FIRE)
                  || (wr_addr == A_PROT);
    end

    // Lock gate, parity gate and event generation for the current write.
    always_comb begin
        access   = wr_en && guarded;
        blocked  = lock && !win_open;
        par_bad  = is_ctl && (^wr_data);
        viol_evt = access && blocked;
        par_evt  = access && par_bad;
        commit   = access && !blocked && !par_bad;
        consume  = access && win_open;
        key_try  = wr_en && (wr_addr == A_KEY);
        clr_mask = (wr_en && (wr_addr == A_FLAGS)) ? wr_data[NFLAG-1:0] : '0;
    end
endmodule

// File: rtl/cfg_guard_unlock.sv
// Module: cfg_guard_unlock
// Compares a key attempt with the stored key and keeps the unlock window,
// which closes on first use or after 2^(BASE_LOG2+exp) cycles.
// Assumes: key_try and consume are never high together.
module cfg_guard_unlock #(
    parameter int unsigned KEY_W     = 16,
    parameter int unsigned EXP_W     = 4,
    parameter int unsigned BASE_LOG2 = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_try,
    input  logic [KEY_W-1:0] key_val,
    input  logic [KEY_W-1:0] stored_key,
    input  logic [EXP_W-1:0] win_exp,
    input  logic             consume,
    output logic             win_open,
    output logic             key_fail
);
    localparam int unsigned CNT_W = BASE_LOG2 + (1 << EXP_W);

    logic             match;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             last;

    // Key comparison and the window length for the current exponent.
    always_comb begin
        match    = (key_val == stored_key);
        key_fail = key_try && !match;
        limit    = CNT_W'(1) << (BASE_LOG2 + int'(win_exp));
        last     = (cnt == limit - CNT_W'(1));
    end

    // Window state: opened by a good key, closed by use or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_open <= 1'b0;
            cnt      <= '0;
        end else if (key_try && match) begin
            win_open <= 1'b1;
            cnt      <= '0;
        end else if (win_open) begin
            if (consume || last) begin
                win_open <= 1'b0;
                cnt      <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // R7: an open window never runs past its length.
    p_window_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        win_open |-> (cnt < limit));

    // R6: a guarded write through the window closes it.
    p_single_use_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !key_try) |=> !win_open);

    // R5: a matching key always leaves the window open.
    p_key_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (key_try && match) |=> win_open);
endmodule

// File: rtl/cfg_guard_regs.sv
// Module: cfg_guard_regs
// Storage for the guarded registers and the sticky write-one-to-clear flags.
// Assumes: commit is already qualified by lock and parity checks.
module cfg_guard_regs
    import cfg_guard_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned VAL_W   = 16,
    parameter int unsigned KEY_W   = 16,
    parameter int unsigned EXP_W   = 4,
    parameter logic [KEY_W-1:0] KEY_RST = 16'hC0DE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NFLAG-1:0]  flag_set,
    input  logic [NFLAG-1:0]  flag_clr,
    output logic [DATA_W-1:0] ctl_a,
    output logic [DATA_W-1:0] ctl_b,
    output logic [VAL_W-1:0]  warn_val,
    output logic [VAL_W-1:0]  fire_val,
    output logic [KEY_W-1:0]  key,
    output logic [EXP_W-1:0]  win_exp,
    output logic [NFLAG-1:0]  flags
);
    // Guarded register file: updates only on a committed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_a    <= '0;
            ctl_b    <= '0;
            warn_val <= '0;
            fire_val <= '0;
            key      <= KEY_RST;
            win_exp  <= '0;
        end else if (commit) begin
            case (wr_addr)
                A_CTL_A: ctl_a    <= wr_data;
                A_CTL_B: ctl_b    <= wr_data;
                A_WARN:  warn_val <= wr_data[VAL_W-1:0];
                A_FIRE:  fire_val <= wr_data[VAL_W-1:0];
                A_PROT: begin
                    key     <= wr_data[KEY_W-1:0];
                    win_exp <= wr_data[EXP_LSB +: EXP_W];
                end
                default: ;
            endcase
        end
    end

    // Sticky flags: set by events, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~flag_clr) | flag_set;
    end

    // R3: a parity event leaves both control words unchanged and flags it.
    p_parity_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set[F_PAR] |=> ($stable(ctl_a) && $stable(ctl_b) && flags[F_PAR]));

    // R4: a lock violation leaves every guarded register unchanged.
    p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set[F_VIOL] |=> ($stable(ctl_a) && $stable(ctl_b) && $stable(warn_val)
                              && $stable(fire_val) && $stable(key) && flags[F_VIOL]));

    // R8: a flag falls only after a write-one to its bit.
    for (genvar i = 0; i < NFLAG; i++) begin : g_w1c
        p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[i]) |-> $past(flag_clr[i]));
    end
endmodule

// File: rtl/cfg_guard.sv
// Module: cfg_guard (top)
// Lock, key-window and parity guard over the watchdog configuration registers,
// with sticky event flags and masked interrupt and reset requests.
// Assumes: a single-cycle write port with no read path.
module cfg_guard
    import cfg_guard_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned VAL_W     = 16,
    parameter int unsigned KEY_W     = 16,
    parameter int unsigned EXP_W     = 4,
    parameter int unsigned BASE_LOG2 = 7,
    parameter logic [KEY_W-1:0] KEY_RST = 16'hC0DE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] ctl_a,
    output logic [DATA_W-1:0] ctl_b,
    output logic [VAL_W-1:0]  warn_val,
    output logic [VAL_W-1:0]  fire_val,
    output logic [2:0]        flags,
    output logic              unlock_open,
    output logic              irq,
    output logic              rst_req
);
    logic             commit;
    logic             consume;
    logic             key_try;
    logic             par_evt;
    logic             viol_evt;
    logic             key_fail;
    logic [NFLAG-1:0] clr_mask;
    logic [NFLAG-1:0] flag_set;
    logic [KEY_W-1:0] key;
    logic [EXP_W-1:0] win_exp;

    cfg_guard_decode #(.DATA_W(DATA_W)) u_decode (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .lock     (ctl_a[LOCK_BIT]),
        .win_open (unlock_open),
        .commit   (commit),
        .consume  (consume),
        .key_try  (key_try),
        .par_evt  (par_evt),
        .viol_evt (viol_evt),
        .clr_mask (clr_mask)
    );

    cfg_guard_unlock #(.KEY_W(KEY_W), .EXP_W(EXP_W), .BASE_LOG2(BASE_LOG2)) u_unlock (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_try    (key_try),
        .key_val    (wr_data[KEY_W-1:0]),
        .stored_key (key),
        .win_exp    (win_exp),
        .consume    (consume),
        .win_open   (unlock_open),
        .key_fail   (key_fail)
    );

    // Gather the three event sources into flag order.
    always_comb begin
        flag_set         = '0;
        flag_set[F_PAR]  = par_evt;
        flag_set[F_VIOL] = viol_evt;
        flag_set[F_KEY]  = key_fail;
    end

    cfg_guard_regs #(
        .DATA_W(DATA_W), .VAL_W(VAL_W), .KEY_W(KEY_W), .EXP_W(EXP_W), .KEY_RST(KEY_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .flag_set (flag_set),
        .flag_clr (clr_mask),
        .ctl_a    (ctl_a),
        .ctl_b    (ctl_b),
        .warn_val (warn_val),
        .fire_val (fire_val),
        .key      (key),
        .win_exp  (win_exp),
        .flags    (flags)
    );

    // Request outputs: flags masked by their per-event enables.
    always_comb begin
        irq     = |(flags & ctl_b[IRQ_EN_LSB +: NFLAG]);
        rst_req = |(flags & ctl_b[RST_EN_LSB +: NFLAG]);
    end
endmodule

// File: tb/cfg_guard_tb_top.sv
// Bench for cfg_guard: a vector table walked by one loop, then directed tests
// for the lock, window boundaries, same-cycle events and reset.
module cfg_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] ctl_a, ctl_b;
    logic [15:0] warn_val, fire_val;
    logic [2:0]  flags;
    logic        unlock_open, irq, rst_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cfg_guard dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctl_a(ctl_a), .ctl_b(ctl_b), .warn_val(warn_val), .fire_val(fire_val),
        .flags(flags), .unlock_open(unlock_open), .irq(irq), .rst_req(rst_req)
    );

    typedef struct packed {
        logic [2:0]  addr;
        logic [31:0] data;
        logic [1:0]  sel;
        logic [31:0] exp_val;
        logic [2:0]  exp_flags;
        logic        exp_irq;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VEC [NVEC] = '{
        '{3'd0, 32'h0000_0006, 2'd0, 32'h0000_0006, 3'b000, 1'b0, 4'd2}, // R2 ctl A
        '{3'd1, 32'h0000_0003, 2'd1, 32'h0000_0003, 3'b000, 1'b0, 4'd2}, // R2 ctl B
        '{3'd2, 32'h0000_1234, 2'd2, 32'h0000_1234, 3'b000, 1'b0, 4'd3}, // R3 no parity on warn
        '{3'd3, 32'h0000_0007, 2'd3, 32'h0000_0007, 3'b000, 1'b0, 4'd3}, // R3 no parity on fire
        '{3'd0, 32'h0000_0001, 2'd0, 32'h0000_0006, 3'b001, 1'b1, 4'd9}, // R3 odd parity, R9 irq
        '{3'd6, 32'h0000_0001, 2'd0, 32'h0000_0006, 3'b000, 1'b0, 4'd8}, // R8 clear
        '{3'd4, 32'h0000_1111, 2'd0, 32'h0000_0006, 3'b100, 1'b0, 4'd5}, // R5 bad key
        '{3'd6, 32'h0000_0002, 2'd0, 32'h0000_0006, 3'b100, 1'b0, 4'd8}, // R8 other bit kept
        '{3'd6, 32'h0000_0004, 2'd0, 32'h0000_0006, 3'b000, 1'b0, 4'd8}  // R8 clear
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Drive one write at the current falling edge; return at the next one.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] pick(input logic [1:0] s);
        case (s)
            2'd0: pick = ctl_a;
            2'd1: pick = ctl_b;
            2'd2: pick = {16'h0, warn_val};
            default: pick = {16'h0, fire_val};
        endcase
    endfunction

    task automatic check_reset_state();
        chk("R1 ctl_a", ctl_a, 32'h0);
        chk("R1 ctl_b", ctl_b, 32'h0);
        chk("R1 warn", {16'h0, warn_val}, 32'h0);
        chk("R1 fire", {16'h0, fire_val}, 32'h0);
        chk("R1 flags", {29'h0, flags}, 32'h0);
        chk("R1 open", {31'h0, unlock_open}, 32'h0);
        chk("R1 reqs", {30'h0, irq, rst_req}, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check_reset_state();
        // R1: the reset key opens the window
        wr(3'd4, 32'h0000_C0DE);
        chk("R1 reset key", {31'h0, unlock_open}, 32'h1);
        wr(3'd2, 32'h0000_0000); // uses the window up

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            wr(VEC[i].addr, VEC[i].data);
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            chk({tag, " val"}, pick(VEC[i].sel), VEC[i].exp_val);
            chk({tag, " flags"}, {29'h0, flags}, {29'h0, VEC[i].exp_flags});
            chk({tag, " irq"}, {31'h0, irq}, {31'h0, VEC[i].exp_irq});
        end

        // Key BEEF, N=0, then set the lock (R2).
        wr(3'd5, 32'h0000_BEEF);
        wr(3'd0, 32'h0000_0003);
        chk("R2 lock set", ctl_a, 32'h3);

        // R4: locked write without unlock.
        wr(3'd2, 32'h0000_0055);
        chk("R4 warn held", {16'h0, warn_val}, 32'h1234);
        chk("R4 flag", {29'h0, flags}, 32'h2);
        chk("R9 irq on viol", {31'h0, irq}, 32'h1);
        wr(3'd6, 32'h2);

        // R5 / R6: unlock, one write, then a violation.
        wr(3'd4, 32'h0000_BEEF);
        chk("R5 open", {31'h0, unlock_open}, 32'h1);
        wr(3'd2, 32'h0000_0042);
        chk("R6 write", {16'h0, warn_val}, 32'h42);
        chk("R6 closed", {31'h0, unlock_open}, 32'h0);
        wr(3'd2, 32'h0000_0099);
        chk("R6 second held", {16'h0, warn_val}, 32'h42);
        chk("R6 second flag", {29'h0, flags}, 32'h2);
        wr(3'd6, 32'h2);

        // R5: wrong key while locked.
        wr(3'd4, 32'h0000_1234);
        chk("R5 fail flag", {29'h0, flags}, 32'h4);
        chk("R5 stays shut", {31'h0, unlock_open}, 32'h0);
        wr(3'd6, 32'h4);

        // R7: window boundary with N=0 (128 cycles).
        wr(3'd4, 32'h0000_BEEF);
        idle(127);
        chk("R7 open at last", {31'h0, unlock_open}, 32'h1);
        wr(3'd3, 32'h0000_00AA);
        chk("R7 last edge ok", {16'h0, fire_val}, 32'hAA);
        wr(3'd4, 32'h0000_BEEF);
        idle(128);
        chk("R7 expired", {31'h0, unlock_open}, 32'h0);
        wr(3'd3, 32'h0000_00BB);
        chk("R7 late held", {16'h0, fire_val}, 32'hAA);
        chk("R7 late flag", {29'h0, flags}, 32'h2);
        wr(3'd6, 32'h2);

        // R7: N=1 doubles the window (256 cycles).
        wr(3'd4, 32'h0000_BEEF);
        wr(3'd5, 32'h0001_BEEF);
        wr(3'd4, 32'h0000_BEEF);
        idle(255);
        chk("R7 N1 open", {31'h0, unlock_open}, 32'h1);
        wr(3'd3, 32'h0000_00CC);
        chk("R7 N1 last ok", {16'h0, fire_val}, 32'hCC);
        wr(3'd4, 32'h0000_BEEF);
        idle(256);
        chk("R7 N1 expired", {31'h0, unlock_open}, 32'h0);

        // R10: lock violation and parity error together.
        wr(3'd1, 32'h0000_0001);
        chk("R10 both flags", {29'h0, flags}, 32'h3);
        chk("R10 ctl_b held", ctl_b, 32'h3);
        wr(3'd6, 32'h3);
        // R10: odd parity through an open window uses the window up.
        wr(3'd4, 32'h0000_BEEF);
        wr(3'd0, 32'h0000_0001);
        chk("R10 par only", {29'h0, flags}, 32'h1);
        chk("R10 ctl_a held", ctl_a, 32'h3);
        chk("R10 consumed", {31'h0, unlock_open}, 32'h0);
        wr(3'd6, 32'h1);

        // R2: release the lock, then write freely.
        wr(3'd4, 32'h0000_BEEF);
        wr(3'd0, 32'h0000_0000);
        chk("R2 unlocked", ctl_a, 32'h0);
        wr(3'd2, 32'h0000_0077);
        chk("R2 free write", {16'h0, warn_val}, 32'h77);

        // R9: reset-enable path.
        wr(3'd1, 32'h0000_0030);
        wr(3'd0, 32'h0000_0001);
        chk("R9 rst_req", {31'h0, rst_req}, 32'h1);
        chk("R9 irq masked", {31'h0, irq}, 32'h0);

        // R1: mid-run reset.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_reset_state();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule